// File: doc/BRIEF.md
# Privileged Trap Entry and Return Sequencer

This block is the trap sequencer of a small core with three privilege levels: User, Supervisor and Machine. When a request strobe is present it takes one of three actions. It can enter a trap, which is an exception or an interrupt carrying a cause code, the trapping PC, an optional trap value and a target level that has already been resolved. It can return from Machine level. It can return from Supervisor level. For each level the block holds the interrupt-enable stack bits, the cause, the exception PC and the trap value. It also holds the current privilege, and it produces the PC the core fetches next.

The trap-vector registers for both levels arrive as inputs. Delegation, interrupt arbitration and CSR access are handled elsewhere. The block computes the target address from the vector register of the level that takes the trap. A request that cannot be honoured changes no state. Such a request is a trap aimed at an unsupported level, or a trap whose vector register holds an illegal mode. It raises a one-cycle error flag in place of a next PC.

Privilege is encoded as User = 2'b00, Supervisor = 2'b01 and Machine = 2'b11. The value 2'b10 is reserved. Every result appears on the outputs in the cycle after the clock edge that sampled the request.

Top module: `priv_trap_unit`

## Requirements
- R1: While reset is asserted and after it is released, the privilege reads 2'b11. All enable, previous-enable and previous-privilege bits read 0, cause/epc/tval of both levels read 0, and no next-PC or error flag is raised.
- R2: With vector mode 0 (tvec bits [1:0] = 0), the next PC is the vector register with its two low bits cleared. This holds for exceptions and for interrupts.
- R3: With vector mode 1, an interrupt goes to base + 4 × cause code, and an exception goes to the plain base.
- R4: A trap whose selected vector register holds mode 2 or 3 pulses err_mode for one cycle and changes no state. No next-PC valid is raised.
- R5: A committed trap to Machine level does all of the following:
  - writes mcause with the interrupt flag in bit 63 and the zero-extended code in the low bits;
  - writes the trapping PC to mepc;
  - copies the old machine enable into the previous-enable bit and clears the enable;
  - stores the pre-trap privilege in the 2-bit previous-privilege field;
  - sets privilege to Machine.
- R6: A committed trap to Supervisor level does the same on the supervisor registers and uses stvec. Its one-bit previous-privilege is 1 if the trap came from Supervisor and 0 if it came from User.
- R7: A trap aimed at User (2'b00), at the reserved code 2'b10, or at Supervisor while running at Machine pulses err_target for one cycle. It changes no state.
- R8: The recorded trap value is 0 for every interrupt. For an exception it is trap_val when trap_val_en is 1, and 0 otherwise.
- R9: A Machine return does all of the following:
  - sets the machine enable to the previous-enable bit;
  - sets the previous-enable bit to 1;
  - moves privilege to the stored previous-privilege;
  - writes User into that field;
  - outputs mepc as next PC.
- R10: A Supervisor return does all of the following:
  - sets the supervisor enable to its previous-enable bit;
  - sets the previous-enable bit to 1;
  - moves privilege to Supervisor if the stored bit is 1 and to User otherwise;
  - clears the stored bit;
  - outputs sepc as next PC.
- R11: Requests act only when req_valid is 1. With req_valid at 0 no state changes and no flag is raised. A trap wins over both returns, and a Machine return wins over a Supervisor return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_trap | input | 1 | Take a trap |
| req_mret | input | 1 | Return from Machine level |
| req_sret | input | 1 | Return from Supervisor level |
| trap_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_code | input | 4 | Cause code |
| trap_pc | input | 64 | PC of the trapping instruction |
| trap_val_en | input | 1 | trap_val carries a value |
| trap_val | input | 64 | Trap value (e.g. faulting address or instruction bits) |
| trap_tgt | input | 2 | Resolved target privilege |
| mtvec_in | input | 64 | Machine trap-vector register |
| stvec_in | input | 64 | Supervisor trap-vector register |
| npc_valid | output | 1 | next_pc was produced by the last request |
| next_pc | output | 64 | Redirect PC |
| err_mode | output | 1 | Illegal vector mode seen |
| err_target | output | 1 | Unsupported trap target seen |
| priv | output | 2 | Current privilege |
| m_ie | output | 1 | Machine interrupt enable |
| m_pie | output | 1 | Machine previous enable |
| m_pp | output | 2 | Machine previous privilege |
| s_ie | output | 1 | Supervisor interrupt enable |
| s_pie | output | 1 | Supervisor previous enable |
| s_pp | output | 1 | Supervisor previous privilege |
| mcause | output | 64 | Machine cause |
| mepc | output | 64 | Machine exception PC |
| mtval | output | 64 | Machine trap value |
| scause | output | 64 | Supervisor cause |
| sepc | output | 64 | Supervisor exception PC |
| stval | output | 64 | Supervisor trap value |

## Verification
The assertions assume the request strobe is synchronous. When it is high, the fields under it are taken as stable for that edge. They also assume the stored Machine previous-privilege never holds the reserved code, which the block guarantees because it only ever writes there the privilege level that was current at the time of the trap. The stimulus drives every request on the falling edge and lets the design reach Supervisor or User level only through its own trap and return paths, so every state the assertions observe is one the block produced itself. The sweeps cover every cause code and interrupt flag under all four vector modes at both levels, and a long random mix adds idle cycles, simultaneous requests and illegal targets.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    PRV_USER = 2'b00,
    PRV_SUP  = 2'b01,
    PRV_RSV  = 2'b10,
    PRV_MACH = 2'b11
  } priv_t;

  typedef enum logic [1:0] {
    VEC_DIRECT = 2'b00,
    VEC_IRQ    = 2'b01,
    VEC_BAD_A  = 2'b10,
    VEC_BAD_B  = 2'b11
  } vmode_t;
endpackage

// File: rtl/trap_rst_sync.sv
module trap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen
  import trap_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int CODE_W = 4
) (
  input  logic [XLEN-1:0]   tvec,
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  output logic [XLEN-1:0]   target,
  output logic              mode_bad
);
  localparam int PAD_W = XLEN - CODE_W - 2;

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;
  vmode_t          mode;

  assign base   = {tvec[XLEN-1:2], 2'b00};
  assign offset = {{PAD_W{1'b0}}, code, 2'b00};
  assign mode   = vmode_t'(tvec[1:0]);

  always_comb begin
    target   = base;
    mode_bad = 1'b0;
    case (mode)
      VEC_DIRECT: target = base;
      VEC_IRQ:    target = is_irq ? (base + offset) : base;
      default:    mode_bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/trap_status_ctrl.sv
module trap_status_ctrl
  import trap_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  do_mtrap,
  input  logic  do_strap,
  input  logic  do_mret,
  input  logic  do_sret,
  output priv_t priv_q,
  output logic  m_ie_q,
  output logic  m_pie_q,
  output priv_t m_pp_q,
  output logic  s_ie_q,
  output logic  s_pie_q,
  output logic  s_pp_q
);
  priv_t priv_d, m_pp_d;
  logic  m_ie_d, m_pie_d, s_ie_d, s_pie_d, s_pp_d;
  logic  upd_en;

  assign upd_en = do_mtrap | do_strap | do_mret | do_sret;

  always_comb begin
    priv_d  = priv_q;
    m_ie_d  = m_ie_q;
    m_pie_d = m_pie_q;
    m_pp_d  = m_pp_q;
    s_ie_d  = s_ie_q;
    s_pie_d = s_pie_q;
    s_pp_d  = s_pp_q;
    if (do_mtrap) begin
      m_pie_d = m_ie_q;
      m_ie_d  = 1'b0;
      m_pp_d  = priv_q;
      priv_d  = PRV_MACH;
    end else if (do_strap) begin
      s_pie_d = s_ie_q;
      s_ie_d  = 1'b0;
      s_pp_d  = (priv_q == PRV_SUP);
      priv_d  = PRV_SUP;
    end else if (do_mret) begin
      m_ie_d  = m_pie_q;
      m_pie_d = 1'b1;
      priv_d  = m_pp_q;
      m_pp_d  = PRV_USER;
    end else if (do_sret) begin
      s_ie_d  = s_pie_q;
      s_pie_d = 1'b1;
      priv_d  = s_pp_q ? PRV_SUP : PRV_USER;
      s_pp_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q  <= PRV_MACH;
      m_ie_q  <= 1'b0;
      m_pie_q <= 1'b0;
      m_pp_q  <= PRV_USER;
      s_ie_q  <= 1'b0;
      s_pie_q <= 1'b0;
      s_pp_q  <= 1'b0;
    end else if (upd_en) begin
      priv_q  <= priv_d;
      m_ie_q  <= m_ie_d;
      m_pie_q <= m_pie_d;
      m_pp_q  <= m_pp_d;
      s_ie_q  <= s_ie_d;
      s_pie_q <= s_pie_d;
      s_pp_q  <= s_pp_d;
    end
  end

  // R5
  mtrap_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_mtrap |=> (priv_q == PRV_MACH) && !m_ie_q && (m_pie_q == $past(m_ie_q))
                 && (m_pp_q == $past(priv_q)));
  // R6
  strap_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_strap |=> (priv_q == PRV_SUP) && !s_ie_q && (s_pie_q == $past(s_ie_q))
                 && (s_pp_q == ($past(priv_q) == PRV_SUP)));
  // R9
  mret_unstack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_mret && !do_mtrap && !do_strap) |=> m_pie_q && (m_pp_q == PRV_USER)
                 && (m_ie_q == $past(m_pie_q)) && (priv_q == $past(m_pp_q)));
  // R10
  sret_unstack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_sret && !do_mtrap && !do_strap && !do_mret) |=> s_pie_q && !s_pp_q
                 && (s_ie_q == $past(s_pie_q)));
endmodule

// File: rtl/priv_trap_unit.sv
module priv_trap_unit
  import trap_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_trap,
  input  logic              req_mret,
  input  logic              req_sret,
  input  logic              trap_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic              trap_val_en,
  input  logic [XLEN-1:0]   trap_val,
  input  logic [1:0]        trap_tgt,
  input  logic [XLEN-1:0]   mtvec_in,
  input  logic [XLEN-1:0]   stvec_in,
  output logic              npc_valid,
  output logic [XLEN-1:0]   next_pc,
  output logic              err_mode,
  output logic              err_target,
  output logic [1:0]        priv,
  output logic              m_ie,
  output logic              m_pie,
  output logic [1:0]        m_pp,
  output logic              s_ie,
  output logic              s_pie,
  output logic              s_pp,
  output logic [XLEN-1:0]   mcause,
  output logic [XLEN-1:0]   mepc,
  output logic [XLEN-1:0]   mtval,
  output logic [XLEN-1:0]   scause,
  output logic [XLEN-1:0]   sepc,
  output logic [XLEN-1:0]   stval
);
  localparam int CAUSE_PAD = XLEN - 1 - CODE_W;

  logic srst_n;

  trap_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  priv_t priv_q, m_pp_q, tgt;
  logic  m_ie_q, m_pie_q, s_ie_q, s_pie_q, s_pp_q;

  assign tgt = priv_t'(trap_tgt);

  // request decode with fixed priority: trap, then Machine return, then Supervisor return
  logic trap_go, mret_go, sret_go;
  assign trap_go = req_valid & req_trap;
  assign mret_go = req_valid & ~req_trap & req_mret;
  assign sret_go = req_valid & ~req_trap & ~req_mret & req_sret;

  logic tgt_bad;
  always_comb begin
    case (tgt)
      PRV_MACH: tgt_bad = 1'b0;
      PRV_SUP:  tgt_bad = (priv_q == PRV_MACH);
      default:  tgt_bad = 1'b1;
    endcase
  end

  logic [XLEN-1:0] tvec_sel, vec_target;
  logic            vec_bad;
  assign tvec_sel = (tgt == PRV_MACH) ? mtvec_in : stvec_in;

  trap_vec_gen #(.XLEN(XLEN), .CODE_W(CODE_W)) u_vec (
    .tvec     (tvec_sel),
    .is_irq   (trap_irq),
    .code     (trap_code),
    .target   (vec_target),
    .mode_bad (vec_bad)
  );

  logic trap_ok, do_mtrap, do_strap, bad_tgt_ev, bad_mode_ev;
  assign bad_tgt_ev  = trap_go & tgt_bad;
  assign bad_mode_ev = trap_go & ~tgt_bad & vec_bad;
  assign trap_ok     = trap_go & ~tgt_bad & ~vec_bad;
  assign do_mtrap    = trap_ok & (tgt == PRV_MACH);
  assign do_strap    = trap_ok & (tgt == PRV_SUP);

  trap_status_ctrl u_stat (
    .clk      (clk),
    .rst_n    (srst_n),
    .do_mtrap (do_mtrap),
    .do_strap (do_strap),
    .do_mret  (mret_go),
    .do_sret  (sret_go),
    .priv_q   (priv_q),
    .m_ie_q   (m_ie_q),
    .m_pie_q  (m_pie_q),
    .m_pp_q   (m_pp_q),
    .s_ie_q   (s_ie_q),
    .s_pie_q  (s_pie_q),
    .s_pp_q   (s_pp_q)
  );

  // cause and trap value shared by both levels
  logic [XLEN-1:0] cause_d, tval_d;
  assign cause_d = {trap_irq, {CAUSE_PAD{1'b0}}, trap_code};
  assign tval_d  = (!trap_irq && trap_val_en) ? trap_val : '0;

  logic [XLEN-1:0] mcause_q, mepc_q, mtval_q, scause_q, sepc_q, stval_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mcause_q <= '0;
      mepc_q   <= '0;
      mtval_q  <= '0;
    end else if (do_mtrap) begin
      mcause_q <= cause_d;
      mepc_q   <= trap_pc;
      mtval_q  <= tval_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      scause_q <= '0;
      sepc_q   <= '0;
      stval_q  <= '0;
    end else if (do_strap) begin
      scause_q <= cause_d;
      sepc_q   <= trap_pc;
      stval_q  <= tval_d;
    end
  end

  // redirect and error outputs
  logic            npc_en;
  logic [XLEN-1:0] npc_d;
  logic            npc_vld_q, err_mode_q, err_tgt_q;
  logic [XLEN-1:0] npc_q;

  assign npc_en = trap_ok | mret_go | sret_go;

  always_comb begin
    if (trap_ok)      npc_d = vec_target;
    else if (mret_go) npc_d = mepc_q;
    else              npc_d = sepc_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      npc_vld_q  <= 1'b0;
      err_mode_q <= 1'b0;
      err_tgt_q  <= 1'b0;
    end else begin
      npc_vld_q  <= npc_en;
      err_mode_q <= bad_mode_ev;
      err_tgt_q  <= bad_tgt_ev;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     npc_q <= '0;
    else if (npc_en) npc_q <= npc_d;
  end

  assign npc_valid  = npc_vld_q;
  assign next_pc    = npc_q;
  assign err_mode   = err_mode_q;
  assign err_target = err_tgt_q;
  assign priv       = priv_q;
  assign m_ie       = m_ie_q;
  assign m_pie      = m_pie_q;
  assign m_pp       = m_pp_q;
  assign s_ie       = s_ie_q;
  assign s_pie      = s_pie_q;
  assign s_pp       = s_pp_q;
  assign mcause     = mcause_q;
  assign mepc       = mepc_q;
  assign mtval      = mtval_q;
  assign scause     = scause_q;
  assign sepc       = sepc_q;
  assign stval      = stval_q;

  // R4
  err_excl_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (err_mode_q || err_tgt_q) |-> !npc_vld_q);
  // R7
  err_frozen_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (bad_tgt_ev || bad_mode_ev) |=> $stable(priv_q) && $stable(mepc_q) && $stable(sepc_q));
  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !req_valid |=> !npc_vld_q && !err_mode_q && !err_tgt_q && $stable(priv_q)
                   && $stable(mcause_q) && $stable(scause_q));
  // R8
  irq_tval_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (do_mtrap && trap_irq) |=> (mtval_q == '0));
endmodule

// File: tb/tb_priv_trap_unit.sv
`timescale 1ns/1ps
module tb_priv_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_trap, req_mret, req_sret;
  logic        trap_irq, trap_val_en;
  logic [3:0]  trap_code;
  logic [63:0] trap_pc, trap_val, mtvec_in, stvec_in;
  logic [1:0]  trap_tgt;
  logic        npc_valid, err_mode, err_target;
  logic [63:0] next_pc;
  logic [1:0]  priv, m_pp;
  logic        m_ie, m_pie, s_ie, s_pie, s_pp;
  logic [63:0] mcause, mepc, mtval, scause, sepc, stval;

  always #2.5 clk = ~clk;

  priv_trap_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_trap(req_trap),
    .req_mret(req_mret), .req_sret(req_sret), .trap_irq(trap_irq),
    .trap_code(trap_code), .trap_pc(trap_pc), .trap_val_en(trap_val_en),
    .trap_val(trap_val), .trap_tgt(trap_tgt), .mtvec_in(mtvec_in),
    .stvec_in(stvec_in), .npc_valid(npc_valid), .next_pc(next_pc),
    .err_mode(err_mode), .err_target(err_target), .priv(priv), .m_ie(m_ie),
    .m_pie(m_pie), .m_pp(m_pp), .s_ie(s_ie), .s_pie(s_pie), .s_pp(s_pp),
    .mcause(mcause), .mepc(mepc), .mtval(mtval), .scause(scause),
    .sepc(sepc), .stval(stval)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // expected state
  logic [1:0]  e_priv, e_mpp;
  logic        e_mie, e_mpie, e_sie, e_spie, e_spp;
  logic [63:0] e_mcause, e_mepc, e_mtval, e_scause, e_sepc, e_stval, e_npc;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [8:0] stat_act();
    return {priv, m_ie, m_pie, m_pp, s_ie, s_pie, s_pp};
  endfunction

  function automatic logic [8:0] stat_exp();
    return {e_priv, e_mie, e_mpie, e_mpp, e_sie, e_spie, e_spp};
  endfunction

  task automatic step(input bit v, input bit t, input bit mr, input bit sr,
                      input bit irq, input logic [3:0] code, input logic [63:0] pc,
                      input bit ven, input logic [63:0] val, input logic [1:0] tgt,
                      input logic [63:0] mt, input logic [63:0] st);
    bit tgt_bad, mode_bad, commit, x_mode, x_tgt;
    logic [63:0] tv, base, cause, tvv;
    string tag;
    req_valid = v; req_trap = t; req_mret = mr; req_sret = sr;
    trap_irq = irq; trap_code = code; trap_pc = pc; trap_val_en = ven;
    trap_val = val; trap_tgt = tgt; mtvec_in = mt; stvec_in = st;
    commit = 0; x_mode = 0; x_tgt = 0; tag = "R11";
    if (v && t) begin
      tgt_bad  = (tgt == 2'b00) || (tgt == 2'b10) || (tgt == 2'b01 && e_priv == 2'b11);
      tv       = (tgt == 2'b11) ? mt : st;
      base     = {tv[63:2], 2'b00};
      mode_bad = !tgt_bad && (tv[1:0] > 2'd1);
      x_tgt    = tgt_bad;
      x_mode   = mode_bad;
      tag      = tgt_bad ? "R7" : (mode_bad ? "R4" : (tv[1:0] == 2'd1 ? "R3" : "R2"));
      if (!tgt_bad && !mode_bad) begin
        commit = 1;
        e_npc  = (tv[1:0] == 2'd1 && irq) ? base + 64'(code) * 64'd4 : base;
        cause  = {irq, 59'd0, code};
        tvv    = irq ? 64'd0 : (ven ? val : 64'd0);
        if (tgt == 2'b11) begin
          e_mcause = cause; e_mepc = pc; e_mtval = tvv;
          e_mpie = e_mie; e_mie = 0; e_mpp = e_priv; e_priv = 2'b11;
        end else begin
          e_scause = cause; e_sepc = pc; e_stval = tvv;
          e_spie = e_sie; e_sie = 0; e_spp = (e_priv == 2'b01); e_priv = 2'b01;
        end
      end
    end else if (v && mr) begin
      commit = 1; tag = "R9";
      e_npc = e_mepc; e_mie = e_mpie; e_mpie = 1; e_priv = e_mpp; e_mpp = 2'b00;
    end else if (v && sr) begin
      commit = 1; tag = "R10";
      e_npc = e_sepc; e_sie = e_spie; e_spie = 1; e_priv = e_spp ? 2'b01 : 2'b00; e_spp = 0;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk({npc_valid, err_mode, err_target} == {commit, x_mode, x_tgt}, tag, "flags",
        {61'd0, npc_valid, err_mode, err_target}, {61'd0, commit, x_mode, x_tgt});
    if (commit) chk(next_pc == e_npc, tag, "next_pc", next_pc, e_npc);
    chk(stat_act() == stat_exp(), tag, "status", {55'd0, stat_act()}, {55'd0, stat_exp()});
    chk({mcause, mepc} == {e_mcause, e_mepc}, "R5", "mcause/mepc", mcause ^ mepc, e_mcause ^ e_mepc);
    chk({scause, sepc} == {e_scause, e_sepc}, "R6", "scause/sepc", scause ^ sepc, e_scause ^ e_sepc);
    chk(mtval == e_mtval, "R8", "mtval", mtval, e_mtval);
    chk(stval == e_stval, "R8", "stval", stval, e_stval);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_trap = 0; req_mret = 0; req_sret = 0;
    trap_irq = 0; trap_code = 0; trap_pc = 0; trap_val_en = 0; trap_val = 0;
    trap_tgt = 0; mtvec_in = 0; stvec_in = 0;
    e_priv = 2'b11; e_mpp = 0; e_mie = 0; e_mpie = 0; e_sie = 0; e_spie = 0; e_spp = 0;
    e_mcause = 0; e_mepc = 0; e_mtval = 0; e_scause = 0; e_sepc = 0; e_stval = 0; e_npc = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(stat_act() == stat_exp(), "R1", "status in reset", {55'd0, stat_act()}, {55'd0, stat_exp()});
    chk({npc_valid, err_mode, err_target} == 3'b0, "R1", "flags in reset",
        {61'd0, npc_valid, err_mode, err_target}, 64'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(stat_act() == stat_exp(), "R1", "status after reset", {55'd0, stat_act()}, {55'd0, stat_exp()});
    chk(mcause == 0 && mepc == 0 && mtval == 0 && scause == 0 && sepc == 0 && stval == 0,
        "R1", "regs after reset", mcause | mepc | mtval | scause | sepc | stval, 64'd0);

    // R7: Supervisor target while at Machine
    step(1, 1, 0, 0, 0, 4'd2, r64(), 1, r64(), 2'b01, 64'h1000, 64'h2000);
    // R11: idle cycle with trap fields present
    step(0, 1, 1, 1, 1, 4'd5, r64(), 1, r64(), 2'b11, 64'h1000, 64'h2000);

    // R2 R3 R4 R5: Machine sweep of every mode, flag and code
    for (int md = 0; md < 4; md++)
      for (int iq = 0; iq < 2; iq++)
        for (int cd = 0; cd < 16; cd++)
          step(1, 1, 0, 0, iq[0], cd[3:0], r64(), cd[0], r64(), 2'b11,
               {r64() >> 2, md[1:0]}, r64());

    // R9: unstack twice, leaving User privilege
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R2 R3 R4 R6: Supervisor sweep
    for (int md = 0; md < 4; md++)
      for (int iq = 0; iq < 2; iq++)
        for (int cd = 0; cd < 16; cd++)
          step(1, 1, 0, 0, iq[0], cd[3:0], r64(), cd[1], r64(), 2'b01,
               r64(), {r64() >> 2, md[1:0]});

    // R10 then R11 priority cases
    step(1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 1, 1, 1, 4'd7, r64(), 0, 0, 2'b11, 64'h4001, 64'h0);
    step(1, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int k;
      logic [1:0] tg;
      k  = $urandom_range(0, 9);
      tg = ($urandom_range(0, 7) == 0) ? 2'($urandom()) : ($urandom_range(0, 1) ? 2'b11 : 2'b01);
      step(k != 0, k < 6, (k == 6) || $urandom_range(0, 3) == 0, k >= 7,
           $urandom_range(0, 1) == 1, 4'($urandom()), r64(), $urandom_range(0, 1) == 1,
           r64(), tg, {r64() >> 2, 2'($urandom_range(0, 2))},
           {r64() >> 2, 2'($urandom_range(0, 2))});
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule